// File: doc/BRIEF.md
# Multiplexed 32-Pin Parallel I/O Port Controller

This block controls a bank of general-purpose pins behind a small word-addressed register bus. Each pin is owned either by the port's own GPIO logic or by one of four internal peripheral functions. The controller produces the pad data, the pad drive enable, the pull resistor controls and a Schmitt-trigger disable for every pin. GPIO output data, drive enable and open-drain behaviour are all programmable per pin.

Each per-pin control field sits behind three addresses: a set port, a clear port and a status word. Writing a one to a set or clear port changes only the pins whose bits are one, so software never needs a read-modify-write to change one pin. Peripheral routing uses two plain read/write select words that together form a 2-bit code per pin. Incoming pad levels are synchronized and then, per pin, passed through unchanged, through a one-cycle glitch rejector, or through a debounce stage that runs on a slow tick whose rate comes from a divider register. The resulting level is readable on the bus and is also driven to the peripherals.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset, the ownership status (word 2) and pull-up status (word 14) read all ones and every other status, select, Schmitt and divider word reads 0, so the pads are undriven and pulled up.
- R2: Control field g (0 ownership, 1 drive enable, 2 output data, 3 pull-up, 4 pull-down, 5 open drain, 6 filter enable, 7 filter mode) has its set port at word 4g, its clear port at 4g+1 and its status at 4g+2. A write to the set port sets exactly the pins whose write bits are one and leaves all other pins unchanged.
- R3: A write to the clear port at word 4g+1 clears exactly the pins whose write bits are one and leaves all other pins unchanged.
- R4: Set ports, clear ports, word 4g+3 and unmapped words read as 0. A write to a status word has no effect.
- R5: Pull-up and pull-down are never both active on one pin: setting pull-up clears pull-down for those pins, and setting pull-down clears pull-up.
- R6: On a GPIO-owned pin (ownership 1) without open drain, the pad data equals the output data bit and the pad drive enable equals the drive-enable bit.
- R7: On a peripheral-owned pin (ownership 0), the code {sel2, sel1} picks the source: sel1 is word 32 and sel2 is word 33. Code 0 selects peripheral A, 1 selects B, 2 selects C and 3 selects D. Peripheral k drives bits k*32+i of the peripheral data and enable inputs.
- R8: With open drain set on a pin, the pad data is 0 and the pad is driven only while the chosen source outputs 0 with its enable set. Otherwise the pad is released. This holds for both GPIO and peripheral sources.
- R9: The Schmitt-disable word (34) and the divider word (35, low 8 bits kept) are plain read/write registers. Each Schmitt bit drives the matching pad Schmitt-disable output.
- R10: The pin-data word (36) and the pin level output give each pad's level two clock edges after it changes when the filter is off, regardless of ownership.
- R11: With the filter on and filter mode 0, a pad pulse lasting one clock is never seen, while a level held for three clocks is accepted.
- R12: With the filter on and filter mode 1, a level is accepted only after three equal samples taken on consecutive slow ticks, one tick every 2*(div+1) clocks. A pulse shorter than two slow periods is never seen.
- R13: The filter-mode field picks between the two filters independently per pin, so the same pulse can pass one pin and be rejected on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_schmitt_off | output | 32 | Schmitt trigger disable |
| per_o | input | 128 | Peripheral output data, four 32-bit slices A to D |
| per_oe | input | 128 | Peripheral drive enables, four slices A to D |
| pin_val | output | 32 | Synchronized, optionally filtered pin levels |

## Verification
Every cycle, the assertions check the set, clear and keep behaviour of the control words, that pulls are mutually exclusive, that set and clear ports read as zero, that GPIO pads follow their data, that open-drain pads never drive high, that the glitch output moves only after two equal synchronized samples, and that the debounce output moves only on a slow tick. The bench scenarios alone can show the register address map, peripheral routing for all four select codes, the exact input latency, and whether pulses of a chosen length pass or are rejected by each filter mode.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    // control field indices; a field's set/clear/status words are 4*g + sub
    localparam int unsigned NGRP      = 8;
    localparam logic [2:0]  G_OWN     = 3'd0;
    localparam logic [2:0]  G_OE      = 3'd1;
    localparam logic [2:0]  G_OUT     = 3'd2;
    localparam logic [2:0]  G_PU      = 3'd3;
    localparam logic [2:0]  G_PD      = 3'd4;
    localparam logic [2:0]  G_ODR     = 3'd5;
    localparam logic [2:0]  G_FEN     = 3'd6;
    localparam logic [2:0]  G_FMODE   = 3'd7;

    localparam logic [1:0]  SUB_SET   = 2'd0;
    localparam logic [1:0]  SUB_CLR   = 2'd1;
    localparam logic [1:0]  SUB_STAT  = 2'd2;

    localparam int unsigned CTL_SPAN  = NGRP * 4;
    localparam int unsigned ADR_SEL1  = 32;
    localparam int unsigned ADR_SEL2  = 33;
    localparam int unsigned ADR_SCHM  = 34;
    localparam int unsigned ADR_DIV   = 35;
    localparam int unsigned ADR_PIN   = 36;

    localparam int unsigned NPER      = 4;
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6,
    parameter int DIVW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] wdata,
    input  logic             we,
    input  logic [NPINS-1:0] pin_val,
    output logic [NPINS-1:0] rdata,
    output logic [NPINS-1:0] own,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] pu,
    output logic [NPINS-1:0] pd,
    output logic [NPINS-1:0] odr,
    output logic [NPINS-1:0] fen,
    output logic [NPINS-1:0] fmode,
    output logic [NPINS-1:0] sel1,
    output logic [NPINS-1:0] sel2,
    output logic [NPINS-1:0] schm,
    output logic [DIVW-1:0]  div
);
    typedef struct packed {
        logic [NGRP-1:0][NPINS-1:0] grp;
        logic [NPINS-1:0]           sel1;
        logic [NPINS-1:0]           sel2;
        logic [NPINS-1:0]           schm;
        logic [DIVW-1:0]            div;
    } regs_t;

    regs_t      regs_q, regs_d;
    logic       ctl_hit;
    logic [2:0] gidx;
    logic [1:0] sub;

    assign ctl_hit = (addr < AW'(CTL_SPAN));
    assign gidx    = addr[4:2];
    assign sub     = addr[1:0];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (ctl_hit) begin
                if (sub == SUB_SET) begin
                    regs_d.grp[gidx] = regs_q.grp[gidx] | wdata;
                    if (gidx == G_PU) regs_d.grp[G_PD] = regs_q.grp[G_PD] & ~wdata;
                    if (gidx == G_PD) regs_d.grp[G_PU] = regs_q.grp[G_PU] & ~wdata;
                end else if (sub == SUB_CLR) begin
                    regs_d.grp[gidx] = regs_q.grp[gidx] & ~wdata;
                end
            end else if (addr == AW'(ADR_SEL1)) begin
                regs_d.sel1 = wdata;
            end else if (addr == AW'(ADR_SEL2)) begin
                regs_d.sel2 = wdata;
            end else if (addr == AW'(ADR_SCHM)) begin
                regs_d.schm = wdata;
            end else if (addr == AW'(ADR_DIV)) begin
                regs_d.div = wdata[DIVW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q            <= '0;
            regs_q.grp[G_OWN] <= '1;
            regs_q.grp[G_PU]  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (ctl_hit) begin
            if (sub == SUB_STAT) rdata = regs_q.grp[gidx];
        end else if (addr == AW'(ADR_SEL1)) begin
            rdata = regs_q.sel1;
        end else if (addr == AW'(ADR_SEL2)) begin
            rdata = regs_q.sel2;
        end else if (addr == AW'(ADR_SCHM)) begin
            rdata = regs_q.schm;
        end else if (addr == AW'(ADR_DIV)) begin
            rdata = NPINS'(regs_q.div);
        end else if (addr == AW'(ADR_PIN)) begin
            rdata = pin_val;
        end
    end

    assign own   = regs_q.grp[G_OWN];
    assign oe    = regs_q.grp[G_OE];
    assign dout  = regs_q.grp[G_OUT];
    assign pu    = regs_q.grp[G_PU];
    assign pd    = regs_q.grp[G_PD];
    assign odr   = regs_q.grp[G_ODR];
    assign fen   = regs_q.grp[G_FEN];
    assign fmode = regs_q.grp[G_FMODE];
    assign sel1  = regs_q.sel1;
    assign sel2  = regs_q.sel2;
    assign schm  = regs_q.schm;
    assign div   = regs_q.div;

    // R2: set port raises the written pins of the drive-enable field
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(4 * G_OE + SUB_SET)) |=> ((oe & $past(wdata)) == $past(wdata)));
    // R2: pins with zero write bits keep their value
    p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(4 * G_OUT + SUB_SET)) |=>
        ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));
    // R3: clear port drops the written pins
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(4 * G_OUT + SUB_CLR)) |=> ((dout & $past(wdata)) == '0));
    // R4: set and clear ports read as zero
    p_strobe_rd0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && sub != SUB_STAT) |-> (rdata == '0));
    // R5: pulls never both on
    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu & pd) == '0));
endmodule

// File: rtl/pio_slow_tick.sv
module pio_slow_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    localparam int CW = DIVW + 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] limit;

    // one tick per 2*(div+1) clocks
    assign limit = {div, 1'b1};
    assign tick  = (cnt_q >= limit);

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_tick_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    input  logic tick,
    input  logic fen,
    input  logic fmode,
    output logic val
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic glt;
        logic smp0;
        logic smp1;
        logic deb;
    } filt_t;

    filt_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pad;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (st_q.s2 == st_q.s3) st_d.glt = st_q.s2;
        if (tick) begin
            st_d.smp0 = st_q.s2;
            st_d.smp1 = st_q.smp0;
            if (st_q.s2 == st_q.smp0 && st_q.smp0 == st_q.smp1) st_d.deb = st_q.s2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = !fen ? st_q.s2 : (fmode ? st_q.deb : st_q.glt);

    // R11: glitch output moves only after two equal synchronized samples
    p_glitch_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.glt != $past(st_q.glt)) |-> ($past(st_q.s2) == $past(st_q.s3)));
    // R12: debounce output moves only on a slow tick
    p_deb_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.deb));
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]      own,
    input  logic [NPINS-1:0]      oe,
    input  logic [NPINS-1:0]      dout,
    input  logic [NPINS-1:0]      odr,
    input  logic [NPINS-1:0]      sel1,
    input  logic [NPINS-1:0]      sel2,
    input  logic [NPER*NPINS-1:0] per_o,
    input  logic [NPER*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]      pad_o,
    output logic [NPINS-1:0]      pad_oe
);
    logic [NPER-1:0][NPINS-1:0] po, poe;

    assign po  = per_o;
    assign poe = per_oe;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [1:0] code;
        logic       src_o, src_oe;

        assign code   = {sel2[i], sel1[i]};
        assign src_o  = own[i] ? dout[i] : po[code][i];
        assign src_oe = own[i] ? oe[i]   : poe[code][i];
        assign pad_o[i]  = src_o & ~odr[i];
        assign pad_oe[i] = odr[i] ? (src_oe & ~src_o) : src_oe;
    end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6,
    parameter int DIVW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic [NPINS-1:0]      bus_wdata,
    input  logic                  bus_we,
    output logic [NPINS-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pad_i,
    output logic [NPINS-1:0]      pad_o,
    output logic [NPINS-1:0]      pad_oe,
    output logic [NPINS-1:0]      pad_pu,
    output logic [NPINS-1:0]      pad_pd,
    output logic [NPINS-1:0]      pad_schmitt_off,
    input  logic [NPER*NPINS-1:0] per_o,
    input  logic [NPER*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]      pin_val
);
    logic [NPINS-1:0] own, oe, dout, odr, fen, fmode, sel1, sel2;
    logic [DIVW-1:0]  div;
    logic             tick;

    pio_regfile #(.NPINS(NPINS), .AW(AW), .DIVW(DIVW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .pin_val(pin_val), .rdata(bus_rdata),
        .own(own), .oe(oe), .dout(dout), .pu(pad_pu), .pd(pad_pd), .odr(odr),
        .fen(fen), .fmode(fmode), .sel1(sel1), .sel2(sel2),
        .schm(pad_schmitt_off), .div(div)
    );

    pio_slow_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_filt
        pio_in_filter u_filt (
            .clk(clk), .rst_n(rst_n), .pad(pad_i[i]), .tick(tick),
            .fen(fen[i]), .fmode(fmode[i]), .val(pin_val[i])
        );
    end

    pio_pad_mux #(.NPINS(NPINS)) u_mux (
        .own(own), .oe(oe), .dout(dout), .odr(odr), .sel1(sel1), .sel2(sel2),
        .per_o(per_o), .per_oe(per_oe), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // R6: GPIO pads without open drain follow the data and enable fields
    p_gpio_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((own & ~odr & ((pad_o ^ dout) | (pad_oe ^ oe))) == '0));
    // R8: an open-drain pad never drives high
    p_odrain_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((odr & pad_o) == '0));
endmodule

// File: tb/tb_pio_port_ctrl.sv
`timescale 1ns/1ps
module tb_pio_port_ctrl;
    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [5:0]     bus_addr = '0;
    logic [N-1:0]   bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic [N-1:0]   bus_rdata;
    logic [N-1:0]   pad_i = '0;
    logic [N-1:0]   pad_o, pad_oe, pad_pu, pad_pd, pad_schmitt_off, pin_val;
    logic [4*N-1:0] per_o = '0;
    logic [4*N-1:0] per_oe = '0;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the programmed state
    logic [N-1:0] m_grp [8];
    logic [N-1:0] m_sel1, m_sel2, m_schm;
    logic [7:0]   m_div;

    always #4 clk = ~clk;

    pio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_schmitt_off(pad_schmitt_off), .per_o(per_o), .per_oe(per_oe),
        .pin_val(pin_val)
    );

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic void model_wr(input int a, input logic [N-1:0] d);
        if (a < 32) begin
            int g = a / 4;
            if (a % 4 == 0) begin
                m_grp[g] |= d;
                if (g == 3) m_grp[4] &= ~d;
                if (g == 4) m_grp[3] &= ~d;
            end else if (a % 4 == 1) begin
                m_grp[g] &= ~d;
            end
        end else if (a == 32) m_sel1 = d;
        else if (a == 33) m_sel2 = d;
        else if (a == 34) m_schm = d;
        else if (a == 35) m_div = d[7:0];
    endfunction

    function automatic logic [N-1:0] exp_rd(input int a);
        if (a < 32) return (a % 4 == 2) ? m_grp[a / 4] : '0;
        if (a == 32) return m_sel1;
        if (a == 33) return m_sel2;
        if (a == 34) return m_schm;
        if (a == 35) return {24'h0, m_div};
        return '0;
    endfunction

    function automatic logic [2*N-1:0] exp_pad();
        logic [N-1:0] eo, eoe;
        for (int i = 0; i < N; i++) begin
            int  k = {m_sel2[i], m_sel1[i]};
            logic so  = m_grp[0][i] ? m_grp[2][i] : per_o[k*N+i];
            logic soe = m_grp[0][i] ? m_grp[1][i] : per_oe[k*N+i];
            eo[i]  = so & ~m_grp[5][i];
            eoe[i] = m_grp[5][i] ? (soe & ~so) : soe;
        end
        return {eo, eoe};
    endfunction

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input int a, output logic [N-1:0] v);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 v = bus_rdata;
    endtask

    task automatic check_all_regs(input string req);
        logic [N-1:0] v;
        for (int a = 0; a < 40; a++) begin
            rd(a, v);
            chk(req, v, exp_rd(a));
        end
    endtask

    task automatic check_pads(input string req);
        logic [2*N-1:0] e;
        #1 e = exp_pad();
        chk({req, " pad_o"}, pad_o, e[2*N-1:N]);
        chk({req, " pad_oe"}, pad_oe, e[N-1:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [N-1:0] v;
        logic seen1, seen2;
        void'($urandom(32'h1bad5eed));
        for (int g = 0; g < 8; g++) m_grp[g] = '0;
        m_grp[0] = '1; m_grp[3] = '1;
        m_sel1 = '0; m_sel2 = '0; m_schm = '0; m_div = '0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check_all_regs("R1 reset regs");
        chk("R1 reset pad_oe", pad_oe, '0);
        chk("R1 reset pad_pu", pad_pu, '1);
        chk("R1 reset pad_pd", pad_pd, '0);

        // R2 / R3 directed set and clear on output data
        wr(8, 32'h0000_00F0);
        rd(10, v); chk("R2 set", v, 32'h0000_00F0);
        wr(8, 32'h0000_0300);
        rd(10, v); chk("R2 set keeps others", v, 32'h0000_03F0);
        wr(9, 32'h0000_0130);
        rd(10, v); chk("R3 clear", v, 32'h0000_02C0);
        // R4 strobe words read zero, status word write ignored
        rd(8, v);  chk("R4 set reads 0", v, '0);
        rd(9, v);  chk("R4 clear reads 0", v, '0);
        wr(10, 32'hFFFF_FFFF);
        rd(10, v); chk("R4 status write ignored", v, 32'h0000_02C0);
        rd(63, v); chk("R4 unmapped", v, '0);

        // R5 pull exclusion
        wr(16, 32'h0000_000F);
        rd(14, v); chk("R5 pd clears pu", v, 32'hFFFF_FFF0);
        wr(12, 32'h0000_0003);
        rd(18, v); chk("R5 pu clears pd", v, 32'h0000_000C);
        chk("R5 pad_pd", pad_pd, 32'h0000_000C);

        // R6 GPIO drive
        wr(4, 32'h0000_0FFF);
        check_pads("R6 gpio");

        // R7 peripheral routing, all four codes
        wr(1, 32'hFFFF_0000);
        per_o  = {32'hF0F0_1234, 32'h0FF0_ABCD, 32'h3C3C_5555, 32'hA5A5_0F0F};
        per_oe = {32'hFFFF_0000, 32'h00FF_FF00, 32'hF00F_0FF0, 32'h5555_AAAA};
        for (int c = 0; c < 4; c++) begin
            wr(32, c[0] ? '1 : '0);
            wr(33, c[1] ? '1 : '0);
            check_pads("R7 periph code");
        end

        // R8 open drain on GPIO and peripheral pins
        wr(20, 32'hFF00_FF00);
        check_pads("R8 open drain");
        chk("R8 no high drive", pad_o & 32'hFF00_FF00, '0);
        wr(21, '1);

        // R9 plain registers
        wr(34, 32'h8421_00FF);
        rd(34, v); chk("R9 schmitt rw", v, 32'h8421_00FF);
        chk("R9 schmitt pad", pad_schmitt_off, 32'h8421_00FF);
        wr(35, 32'h0000_01A7);
        rd(35, v); chk("R9 div rw", v, 32'h0000_00A7);

        // random set/clear/select traffic against the model
        for (int it = 0; it < 400; it++) begin
            int a;
            if ($urandom_range(0, 7) == 0) a = 32 + $urandom_range(0, 2);
            else a = $urandom_range(0, 31);
            if (it % 50 == 0) begin
                per_o  = {$urandom, $urandom, $urandom, $urandom};
                per_oe = {$urandom, $urandom, $urandom, $urandom};
            end
            wr(a, $urandom);
            if (it % 40 == 39) begin
                check_all_regs("R2 R3 random regs");
                check_pads("R6 R7 R8 random pads");
                chk("R5 random pulls", pad_pu & pad_pd, '0);
            end
        end

        // filter scenarios: restore a clean setup
        wr(1, '1); wr(25, '1); wr(29, '1); wr(21, '1);
        pad_i = '0;
        repeat (6) @(posedge clk);

        // R10 unfiltered, pin 0 peripheral-owned, two-edge latency
        @(negedge clk); bus_addr = 6'd36; pad_i[0] = 1'b1;
        @(posedge clk); #1 chk("R10 one edge", {31'h0, bus_rdata[0]}, 32'h0);
        @(posedge clk); #1 chk("R10 two edges", {31'h0, bus_rdata[0]}, 32'h1);
        chk("R10 pin_val", {31'h0, pin_val[0]}, 32'h1);

        // pin 1 glitch filter, pin 2 debounce with div = 2 (period 6)
        wr(35, 32'd2);
        wr(24, 32'h0000_0006);
        wr(28, 32'h0000_0004);
        repeat (20) @(posedge clk);

        // R11 one-clock pulse rejected
        @(negedge clk); bus_addr = 6'd36; pad_i[1] = 1'b1;
        @(negedge clk); pad_i[1] = 1'b0;
        seen1 = 1'b0;
        repeat (10) begin @(posedge clk); #1 seen1 |= bus_rdata[1]; end
        chk("R11 one-clock pulse rejected", {31'h0, seen1}, 32'h0);

        // R11 R13 three-clock pulse: passes glitch pin, rejected on debounce pin
        @(negedge clk); pad_i[2:1] = 2'b11;
        repeat (3) @(negedge clk);
        pad_i[2:1] = 2'b00;
        seen1 = 1'b0; seen2 = 1'b0;
        repeat (50) begin @(posedge clk); #1 seen1 |= bus_rdata[1]; seen2 |= bus_rdata[2]; end
        chk("R11 three-clock pulse accepted", {31'h0, seen1}, 32'h1);
        chk("R13 same pulse rejected by debounce", {31'h0, seen2}, 32'h0);

        // R12 pulse of two slow periods rejected, long level accepted
        @(negedge clk); pad_i[2] = 1'b1;
        repeat (12) @(negedge clk);
        pad_i[2] = 1'b0;
        seen2 = 1'b0;
        repeat (50) begin @(posedge clk); #1 seen2 |= bus_rdata[2]; end
        chk("R12 short pulse rejected", {31'h0, seen2}, 32'h0);
        @(negedge clk); pad_i[2] = 1'b1;
        repeat (60) @(posedge clk);
        #1 chk("R12 held level accepted", {31'h0, bus_rdata[2]}, 32'h1);

        report();
    end
endmodule